// File: doc/BRIEF.md
# Firmware Record Stream Loader

This block takes a firmware image as a stream of bytes whose total length is given when the load starts. The image is a series of records placed one after another. Each record starts with a six-byte header and then carries a payload. The loader parses the records as the bytes arrive and turns every payload byte into a single-byte write on a memory write port. The target addresses run upward from the destination given in the header.

Before it accepts a header, the loader checks that the header fits inside the bytes the image has left. Before it writes any payload, it checks that the payload fits as well. If a check fails, loading stops at once and the block reports an image error. When the bytes consumed reach the declared length exactly, the block reports success. Both outcomes are reported only after the last write has left the write port.

The byte input and the write port are valid/ready streams. The write port holds one write in an output register. While that write is stalled (`wr_valid` high, `wr_ready` low), the address and data stay frozen and no further payload byte is taken from the input. The input accepts a byte only in a cycle where `in_valid` and `in_ready` are both high. Control and status are plain level signals.

Top module: `fw_record_loader`

## Requirements
- R1: A record is a 4-byte destination address, then a 2-byte length, then exactly that many payload bytes. Both header fields are little-endian: the first byte received is the least significant.
- R2: Payload byte k of a record (k counted from 0) is written to destination+k, one byte per accepted write, in stream order. The address wraps modulo 2^32.
- R3: When a record is about to start and 1 to 5 image bytes remain, loading stops with `error`=1. None of those bytes is consumed.
- R4: When a record's length exceeds the image bytes left after its header, loading stops with `error`=1. No byte of that payload is consumed or written.
- R5: When the bytes consumed equal `image_len` at a record boundary, the block reports `done`=1 and `error`=0. An image of length 0 completes with no writes.
- R6: A record of length 0 produces no writes, and parsing continues with the next record.
- R7: While `wr_valid`=1 and `wr_ready`=0, `wr_valid`, `wr_addr` and `wr_data` hold their values. No payload byte is accepted while the write register is full and not draining.
- R8: `done` and `error` are never high together. Each stays set until the next accepted `start`, which clears both. A `start` that arrives while `busy`=1 is ignored.
- R9: `bytes_written` counts the writes accepted on the write port since the last accepted `start`. It is cleared by that `start`.
- R10: `in_ready` is 0 whenever `busy` is 0.
- R11: `done` or `error` rises only when `wr_valid` is 0, that is, after the last write has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load; taken only when `busy`=0 |
| image_len | input | IMG_W | Image length in bytes; sampled when `start` is taken |
| in_valid | input | 1 | Image byte valid |
| in_data | input | 8 | Image byte |
| in_ready | output | 1 | Loader accepts `in_data` this cycle |
| wr_valid | output | 1 | Write request pending |
| wr_addr | output | ADDR_W | Byte address of the write |
| wr_data | output | 8 | Byte to write |
| wr_ready | input | 1 | Memory accepts the pending write |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Sticky: the image loaded completely |
| error | output | 1 | Sticky: the image was malformed |
| bytes_written | output | IMG_W | Writes accepted since the last start |

## Verification
The bench targets several boundary cases:
- A trailing fragment shorter than a header. A loader that read a partial header would swallow bytes and hang waiting for more; one that only checked for zero would write garbage.
- A length field one past the bytes that remain. An off-by-one bound would write the payload, or stop too early on a record that fits exactly.
- Zero-length records, an empty image, and destinations that wrap past the top of the address space. These catch a length counter that underflows or an address that does not carry.
- Random back-pressure on both streams, plus a `start` pulse in the middle of a load. A design that drops or repeats a byte under a stall, or that restarts while busy, shows up as a write list that does not match.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_CHK,
    ST_DATA,
    ST_FIN
  } fwl_state_e;
endpackage

// File: rtl/fwl_hdr_shift.sv
module fwl_hdr_shift #(
  parameter int ADDR_W = 32,
  parameter int RLEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift,
  input  logic [7:0]        in_byte,
  output logic              at_first,
  output logic              last,
  output logic [ADDR_W-1:0] hdr_addr,
  output logic [RLEN_W-1:0] hdr_len
);
  localparam int NB = (ADDR_W + RLEN_W) / 8;
  localparam int HW = NB * 8;
  localparam int CW = $clog2(NB + 1);

  logic [HW-1:0] hdr_q;
  logic [CW-1:0] cnt_q;

  assign at_first = (cnt_q == '0);
  assign last     = shift && (cnt_q == CW'(NB - 1));
  assign hdr_addr = hdr_q[ADDR_W-1:0];
  assign hdr_len  = hdr_q[HW-1:ADDR_W];

  // little-endian: each new byte enters at the top and earlier ones move down
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hdr_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (shift) begin
      hdr_q <= {in_byte, hdr_q[HW-1:8]};
      cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fwl_budget.sv
module fwl_budget #(
  parameter int IMG_W     = 20,
  parameter int RLEN_W    = 16,
  parameter int HDR_BYTES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [IMG_W-1:0]  load_val,
  input  logic              dec,
  input  logic [RLEN_W-1:0] rec_len,
  output logic              rem_empty,
  output logic              rem_short,
  output logic              overrun
);
  localparam int CW = (IMG_W > RLEN_W) ? IMG_W : RLEN_W;

  logic [IMG_W-1:0] rem_q;

  assign rem_empty = (rem_q == '0);
  assign rem_short = (CW'(rem_q) < CW'(HDR_BYTES));
  assign overrun   = (CW'(rec_len) > CW'(rem_q));

  always_ff @(posedge clk) begin
    if (!rst_n)    rem_q <= '0;
    else if (load) rem_q <= load_val;
    else if (dec)  rem_q <= rem_q - 1'b1;
  end
endmodule

// File: rtl/fwl_wr_stage.sv
module fwl_wr_stage #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [7:0]        push_data,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              free
);
  assign free = !wr_valid || wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (push) begin
      wr_valid <= 1'b1;
      wr_addr  <= push_addr;
      wr_data  <= push_data;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fw_record_loader.sv
module fw_record_loader
  import fwl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int RLEN_W = 16,
  parameter int IMG_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IMG_W-1:0]  image_len,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  input  logic              wr_ready,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [IMG_W-1:0]  bytes_written
);
  localparam int HDR_BYTES = (ADDR_W + RLEN_W) / 8;

  fwl_state_e        state_q, state_d;
  logic [ADDR_W-1:0] cur_addr_q;
  logic [RLEN_W-1:0] plen_q;
  logic              res_err_q, res_err_d;
  logic              done_q, err_q;
  logic [IMG_W-1:0]  wcount_q;

  logic              take, go;
  logic              hdr_first, hdr_last;
  logic [ADDR_W-1:0] hdr_addr;
  logic [RLEN_W-1:0] hdr_len;
  logic              rem_empty, rem_short, overrun;
  logic              wr_free, push;

  assign go   = start && (state_q == ST_IDLE);
  assign take = in_valid && in_ready;
  assign push = take && (state_q == ST_DATA);

  fwl_hdr_shift #(.ADDR_W(ADDR_W), .RLEN_W(RLEN_W)) u_hdr (
    .clk(clk), .rst_n(rst_n), .clr(go),
    .shift(take && (state_q == ST_HDR)), .in_byte(in_data),
    .at_first(hdr_first), .last(hdr_last),
    .hdr_addr(hdr_addr), .hdr_len(hdr_len)
  );

  fwl_budget #(.IMG_W(IMG_W), .RLEN_W(RLEN_W), .HDR_BYTES(HDR_BYTES)) u_budget (
    .clk(clk), .rst_n(rst_n), .load(go), .load_val(image_len),
    .dec(take), .rec_len(hdr_len),
    .rem_empty(rem_empty), .rem_short(rem_short), .overrun(overrun)
  );

  fwl_wr_stage #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .push(push), .push_addr(cur_addr_q),
    .push_data(in_data), .wr_ready(wr_ready), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .free(wr_free)
  );

  always_comb begin
    state_d   = state_q;
    res_err_d = res_err_q;
    in_ready  = 1'b0;
    case (state_q)
      ST_IDLE: if (go) begin
        state_d   = ST_HDR;
        res_err_d = 1'b0;
      end
      ST_HDR: begin
        if (hdr_first && rem_empty) begin
          state_d = ST_FIN;
        end else if (hdr_first && rem_short) begin
          state_d   = ST_FIN;
          res_err_d = 1'b1;
        end else begin
          in_ready = 1'b1;
          if (take && hdr_last) state_d = ST_CHK;
        end
      end
      ST_CHK: begin
        if (overrun) begin
          state_d   = ST_FIN;
          res_err_d = 1'b1;
        end else if (hdr_len == '0) begin
          state_d = ST_HDR;
        end else begin
          state_d = ST_DATA;
        end
      end
      ST_DATA: begin
        in_ready = wr_free;
        if (take && plen_q == RLEN_W'(1)) state_d = ST_HDR;
      end
      ST_FIN: if (!wr_valid) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      res_err_q  <= 1'b0;
      cur_addr_q <= '0;
      plen_q     <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      wcount_q   <= '0;
    end else begin
      state_q   <= state_d;
      res_err_q <= res_err_d;
      if (state_q == ST_CHK) begin
        cur_addr_q <= hdr_addr;
        plen_q     <= hdr_len;
      end else if (push) begin
        cur_addr_q <= cur_addr_q + 1'b1;
        plen_q     <= plen_q - 1'b1;
      end
      if (go) begin
        done_q   <= 1'b0;
        err_q    <= 1'b0;
        wcount_q <= '0;
      end else begin
        if (wr_valid && wr_ready) wcount_q <= wcount_q + 1'b1;
        if (state_q == ST_FIN && !wr_valid) begin
          done_q <= !res_err_q;
          err_q  <= res_err_q;
        end
      end
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign done          = done_q;
  assign error         = err_q;
  assign bytes_written = wcount_q;
endmodule

// File: rtl/fwl_checker.sv
module fwl_checker #(
  parameter int ADDR_W = 32,
  parameter int IMG_W  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              in_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic [IMG_W-1:0]  bytes_written
);
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R7
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error)); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) && !start |=> $stable(done) && $stable(error)); // R8
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> !done && !error && bytes_written == '0); // R9
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> bytes_written == $past(bytes_written) + 1'b1); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready); // R10
  AST_FINISH_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) || $rose(error) |-> !wr_valid); // R11
endmodule

bind fw_record_loader fwl_checker #(.ADDR_W(ADDR_W), .IMG_W(IMG_W)) u_fwl_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .in_ready(in_ready),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .busy(busy), .done(done), .error(error), .bytes_written(bytes_written)
);

// File: tb/fw_record_loader_test.sv
`timescale 1ns/1ps
module fw_record_loader_test;
  localparam int IMG_W = 20;
  localparam int MAXB  = 256;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [IMG_W-1:0] image_len = '0;
  logic in_valid = 1'b0, wr_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, wr_valid, busy, done, error;
  logic [31:0] wr_addr;
  logic [7:0] wr_data;
  logic [IMG_W-1:0] bytes_written;

  fw_record_loader #(.ADDR_W(32), .RLEN_W(16), .IMG_W(IMG_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .image_len(image_len),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
    .busy(busy), .done(done), .error(error), .bytes_written(bytes_written)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0]  img [MAXB];
  logic [31:0] exp_addr [MAXB];
  logic [7:0]  exp_data [MAXB];
  int exp_n, exp_used, wp;
  bit exp_err;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference parser: walks the image per R1..R6
  task automatic model(input int n);
    int p = 0;
    exp_n = 0; exp_err = 0;
    forever begin
      logic [31:0] dst; int len;
      if (p == n) break;
      if (n - p < 6) begin exp_err = 1; break; end
      dst = {img[p+3], img[p+2], img[p+1], img[p]};
      len = {img[p+5], img[p+4]};
      p += 6;
      if (len > n - p) begin exp_err = 1; break; end
      for (int k = 0; k < len; k++) begin
        exp_addr[exp_n] = dst + 32'(k);
        exp_data[exp_n] = img[p+k];
        exp_n++;
      end
      p += len;
    end
    exp_used = p;
  endtask

  task automatic put_rec(input logic [31:0] dst, input int len);
    img[wp] = dst[7:0]; img[wp+1] = dst[15:8]; img[wp+2] = dst[23:16]; img[wp+3] = dst[31:24];
    img[wp+4] = len[7:0]; img[wp+5] = len[15:8];
    wp += 6;
    for (int k = 0; k < len && wp < MAXB; k++) begin img[wp] = 8'($urandom); wp++; end
  endtask

  task automatic run_image(input int n, input bit poke, input string tag);
    int idx = 0, got = 0, cyc = 0, bad = 0, first_bad = -1;
    logic [IMG_W-1:0] bw;
    model(n);
    @(negedge clk); image_len = IMG_W'(n); start = 1'b1; in_valid = 1'b0;
    @(negedge clk); start = 1'b0;
    while (cyc < 5000) begin
      @(negedge clk); cyc++;
      start    = poke && (cyc == 3);
      in_valid = (idx < n) && ($urandom_range(0, 3) != 0);
      in_data  = (idx < n) ? img[idx] : 8'h00;
      wr_ready = ($urandom_range(0, 2) != 0);
      #1;
      if (in_valid && in_ready) idx++;
      if (wr_valid && wr_ready) begin
        if (got >= exp_n || wr_addr != exp_addr[got] || wr_data != exp_data[got]) begin
          bad++; if (first_bad < 0) first_bad = got;
        end
        got++;
      end
      if (done || error) break;
    end
    start = 1'b0; in_valid = 1'b0;
    check(error == exp_err && done == !exp_err, {tag, " R5 R3 R4 status"}, {done, error}, {!exp_err, exp_err});
    check(idx == exp_used, {tag, " R3 R4 bytes consumed"}, idx, exp_used);
    check(got == exp_n, {tag, " R2 R6 write count"}, got, exp_n);
    check(bad == 0, {tag, " R1 R2 R7 write address/data"}, first_bad, -1);
    check(bytes_written == IMG_W'(exp_n), {tag, " R9 bytes_written"}, bytes_written, exp_n);
    bw = bytes_written;
    repeat (4) @(negedge clk);
    #1;
    check(done == !exp_err && error == exp_err && bytes_written == bw && !in_ready && !busy,
          {tag, " R8 R10 sticky idle"}, {done, error, in_ready}, {!exp_err, exp_err, 1'b0});
  endtask

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!busy && !done && !error && !in_ready && !wr_valid && bytes_written == '0,
          "reset R8 R10", {busy, done, error, in_ready, wr_valid}, 0);

    wp = 0; put_rec(32'h1234_5678, 3);
    run_image(wp, 0, "single R1");

    wp = 0; put_rec(32'h100, 0); put_rec(32'h200, 2); put_rec(32'h300, 0);
    run_image(wp, 0, "zero-len R6");

    run_image(0, 0, "empty R5");

    wp = 0; put_rec(32'h40, 4); img[wp] = 8'h11; img[wp+1] = 8'h22; img[wp+2] = 8'h33; wp += 3;
    run_image(wp, 0, "short-tail R3");

    wp = 0; put_rec(32'h80, 2);
    img[wp] = 8'h00; img[wp+1] = 8'h90; img[wp+2] = 8'h00; img[wp+3] = 8'h00;
    img[wp+4] = 8'd11; img[wp+5] = 8'h00; wp += 6;
    for (int k = 0; k < 10; k++) begin img[wp] = 8'(k); wp++; end
    run_image(wp, 0, "overrun R4");

    wp = 0; put_rec(32'h80, 2);
    img[wp] = 8'h00; img[wp+1] = 8'h90; img[wp+2] = 8'h00; img[wp+3] = 8'h00;
    img[wp+4] = 8'd10; img[wp+5] = 8'h00; wp += 6;
    for (int k = 0; k < 10; k++) begin img[wp] = 8'(k); wp++; end
    run_image(wp, 0, "exact-fit R4");

    wp = 0; put_rec(32'hFFFF_FFFE, 4);
    run_image(wp, 0, "wrap R2");

    wp = 0; put_rec(32'hA000, 20); put_rec(32'hB000, 5);
    run_image(wp, 1, "start-busy R8");

    for (int r = 0; r < 25; r++) begin
      int nrec = $urandom_range(1, 4);
      wp = 0;
      for (int q = 0; q < nrec; q++)
        put_rec(($urandom_range(0, 5) == 0) ? 32'hFFFF_FFF0 : $urandom, $urandom_range(0, 40));
      if (r % 3 == 1) wp = wp + $urandom_range(1, 5);
      if (r % 3 == 2) wp = wp - $urandom_range(1, 4);
      if (wp > MAXB) wp = MAXB;
      run_image(wp, 0, "random R7");
    end

    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule